// File: doc/BRIEF.md
# Flash Block Lock Manager

This block holds the write-protection state of every erase block in a small flash array. Each block is held in one of three states: unlocked, locked, or lock-tight. Lock-tight is sticky and can only be left through reset. Software loads a first and a last block index into two address registers and then issues a one-byte command. The command can unlock a range, unlock every block, lock a range, or promote a range to lock-tight.

An accepted command walks its block range one block per clock. Each block moves to the state the command asks for, unless its present state forbids the move. Any block whose state really changes also copies its new state into a 16-bit write-protect status register. A busy output covers the walk, and a one-cycle done pulse ends it. If the walk steps past the last existing block, a command-error flag is raised and the walk stops there. A combinational query port returns the state of any block, for use by the program and erase logic outside this block.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset every block reads locked (3'b010), the write-protect status is 16'h0002, and busy, done and the error flag are low.
- R2: Block states are one-hot: lock-tight 3'b001, locked 3'b010, unlocked 3'b100. The query port returns the addressed block's state in the same cycle, and 3'b000 for an index at or above the block count.
- R3: Command codes: 8'h23 unlocks blocks from the first to the last index inclusive, 8'h27 unlocks every block, 8'h2A locks the range, 8'h2C makes the range lock-tight.
- R4: Unlock and lock commands leave a lock-tight block unchanged.
- R5: The lock-tight command leaves unlocked blocks unchanged, so only locked blocks become lock-tight.
- R6: When the walk reaches an index at or above the block count, the error flag is set and the walk ends in that cycle. The flag stays set until the next command is accepted, which clears it.
- R7: The write-protect status changes only when a block's state really changes, and it then holds 13 zero bits followed by that block's new state.
- R8: A write to the first-index register (select 0) stores the value ANDed with (block count − 1) and also copies it into the last-index register. A write to the last-index register (select 1) stores the full value and changes only that register.
- R9: One block is handled per cycle. Busy is high from the cycle after acceptance and lasts one cycle per block handled, one cycle for an error step, or one cycle for an empty range (first > last, no change). A one-cycle done pulse follows the last busy cycle.
- R10: A command offered while busy is ignored, and so is any command code outside those in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command code |
| reg_wr | input | 1 | Address register write strobe |
| reg_sel | input | 1 | 0 selects the first-index register, 1 the last-index register |
| reg_wdata | input | AW | Address register write value |
| start_addr | output | AW | First-index register |
| end_addr | output | AW | Last-index register |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| cmd_err | output | 1 | Walk left the array |
| wp_status | output | 16 | Most recently changed block state |
| q_idx | input | AW | Query block index |
| q_state | output | 3 | State of the queried block |

## Verification
Register writes show up on the address outputs one edge after the strobe. Query results are combinational and are read a short delay after the index is set, away from any edge. For each command the bench first works out how many walk cycles are due: blocks handled up to the last index, or up to and including the out-of-range step, or one for an empty range. After acceptance it counts falling edges until done and compares that count to the expected cycle count. Only after done does it compare the error flag, the status register and every block's state against its own model.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef logic [2:0] lk_state_t;

    localparam lk_state_t LK_TIGHT    = 3'b001;
    localparam lk_state_t LK_LOCKED   = 3'b010;
    localparam lk_state_t LK_UNLOCKED = 3'b100;

    typedef enum logic [1:0] {
        OP_UNLOCK     = 2'd0,
        OP_UNLOCK_ALL = 2'd1,
        OP_LOCK       = 2'd2,
        OP_TIGHT      = 2'd3
    } lk_op_t;

    localparam logic [7:0] CODE_UNLOCK     = 8'h23;
    localparam logic [7:0] CODE_UNLOCK_ALL = 8'h27;
    localparam logic [7:0] CODE_LOCK       = 8'h2A;
    localparam logic [7:0] CODE_TIGHT      = 8'h2C;

    // Target state of one block under one operation, honouring the stickiness rules.
    function automatic lk_state_t lk_apply(lk_op_t op, lk_state_t cur);
        lk_state_t nxt;
        nxt = cur;
        unique case (op)
            OP_UNLOCK, OP_UNLOCK_ALL: if (cur != LK_TIGHT)    nxt = LK_UNLOCKED;
            OP_LOCK:                  if (cur != LK_TIGHT)    nxt = LK_LOCKED;
            OP_TIGHT:                 if (cur != LK_UNLOCKED) nxt = LK_TIGHT;
            default:                  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/flk_addr_regs.sv
module flk_addr_regs #(
    parameter int NUM_BLOCKS = 16,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] first_q,
    output logic [AW-1:0] last_q
);

    localparam logic [AW-1:0] IDX_MASK = AW'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic [AW-1:0] first;
        logic [AW-1:0] last;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr) begin
            if (!sel) begin
                d.first = wdata & IDX_MASK;
                d.last  = wdata & IDX_MASK;
            end else begin
                d.last  = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign first_q = q.first;
    assign last_q  = q.last;

    // R8: a first-index write leaves both registers equal
    a_r8_copy_to_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> (last_q == first_q));

    // R8: a last-index write leaves the first-index register alone
    a_r8_last_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel) |=> $stable(first_q));

endmodule

// File: rtl/flk_state_array.sv
module flk_state_array
    import flk_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  lk_state_t     wr_val,
    input  logic [AW-1:0] rd_idx,
    output lk_state_t     rd_val,
    input  logic [AW-1:0] q_idx,
    output lk_state_t     q_val
);

    lk_state_t st_q [NUM_BLOCKS];

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        lk_state_t st_d;

        always_comb begin
            st_d = st_q[i];
            if (wr_en && (wr_idx == AW'(i))) st_d = wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[i] <= LK_LOCKED;
            else        st_q[i] <= st_d;
        end

        // R2: storage always holds a single one-hot state
        a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(st_q[i]) == 1);

        // R4: once lock-tight, a block stays lock-tight until reset
        a_r4_tight_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[i] == LK_TIGHT) |=> (st_q[i] == LK_TIGHT));

        // R5: an unlocked block never moves straight to lock-tight
        a_r5_no_unlocked_to_tight: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[i] == LK_UNLOCKED) |=> (st_q[i] != LK_TIGHT));
    end

    always_comb begin
        rd_val = '0;
        q_val  = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (rd_idx == AW'(i)) rd_val = st_q[i];
            if (q_idx  == AW'(i)) q_val  = st_q[i];
        end
    end

endmodule

// File: rtl/flk_walker.sv
module flk_walker #(
    parameter int NUM_BLOCKS = 16,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] last,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          step_valid,
    output logic [AW-1:0] step_idx
);

    localparam logic [AW:0] NB_EXT = (AW + 1)'(NUM_BLOCKS);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          err;
        logic [AW-1:0] cur;
        logic [AW-1:0] last;
    } walk_t;

    walk_t q, d;
    logic  past_end;
    logic  out_of_range;

    always_comb begin
        past_end     = q.cur > q.last;
        out_of_range = {1'b0, q.cur} >= NB_EXT;
        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.err  = 1'b0;
            d.cur  = first;
            d.last = last;
        end else if (q.busy) begin
            if (past_end) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else if (out_of_range) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.err  = 1'b1;
            end else if (q.cur == q.last) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cur = q.cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign err        = q.err;
    assign step_valid = q.busy && !past_end && !out_of_range;
    assign step_idx   = q.cur;

    // R9: busy only ends with a done pulse
    a_r9_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the error flag only rises as a walk finishes
    a_r6_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R9: the walk index advances by one per busy cycle
    a_r9_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && $past(busy) && !done && $past(step_valid))
            |-> (step_idx == $past(step_idx) + 1'b1));

endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
    import flk_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int AW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_op,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] end_addr,
    output logic          busy,
    output logic          done,
    output logic          cmd_err,
    output logic [15:0]   wp_status,
    input  logic [AW-1:0] q_idx,
    output logic [2:0]    q_state
);

    localparam logic [15:0]   WP_RESET = 16'h0002;
    localparam logic [AW-1:0] LAST_BLK = AW'(NUM_BLOCKS - 1);

    typedef struct packed {
        lk_op_t      op;
        logic [15:0] wp;
    } ctl_t;

    ctl_t          q, d;
    logic          known;
    lk_op_t        dec_op;
    logic          accept;
    logic [AW-1:0] walk_first;
    logic [AW-1:0] walk_last;
    logic          step_valid;
    logic [AW-1:0] step_idx;
    lk_state_t     cur_state;
    lk_state_t     new_state;
    logic          changed;
    lk_state_t     q_val;

    always_comb begin
        known  = 1'b1;
        dec_op = OP_UNLOCK;
        unique case (cmd_op)
            CODE_UNLOCK:     dec_op = OP_UNLOCK;
            CODE_UNLOCK_ALL: dec_op = OP_UNLOCK_ALL;
            CODE_LOCK:       dec_op = OP_LOCK;
            CODE_TIGHT:      dec_op = OP_TIGHT;
            default:         known  = 1'b0;
        endcase
        accept = cmd_valid && known && !busy;
        if (dec_op == OP_UNLOCK_ALL) begin
            walk_first = '0;
            walk_last  = LAST_BLK;
        end else begin
            walk_first = start_addr;
            walk_last  = end_addr;
        end
    end

    always_comb begin
        new_state = lk_apply(q.op, cur_state);
        changed   = step_valid && (new_state != cur_state);
        d = q;
        if (accept)  d.op = dec_op;
        if (changed) d.wp = {13'b0, new_state};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.op <= OP_UNLOCK;
            q.wp <= WP_RESET;
        end else begin
            q <= d;
        end
    end

    flk_addr_regs #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .first_q (start_addr),
        .last_q  (end_addr)
    );

    flk_walker #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .first      (walk_first),
        .last       (walk_last),
        .busy       (busy),
        .done       (done),
        .err        (cmd_err),
        .step_valid (step_valid),
        .step_idx   (step_idx)
    );

    flk_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (changed),
        .wr_idx (step_idx),
        .wr_val (new_state),
        .rd_idx (step_idx),
        .rd_val (cur_state),
        .q_idx  (q_idx),
        .q_val  (q_val)
    );

    assign wp_status = q.wp;
    assign q_state   = q_val;

    // R7: the status register only moves after a block handled in the walk
    a_r7_wp_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_status) |-> $past(step_valid));

    // R7: the status register always carries a one-hot state in its low bits
    a_r7_wp_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_status[15:3] == '0) && ($countones(wp_status[2:0]) == 1));

    // R10: a command offered during a walk does not replace the active operation
    a_r10_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(q.op));

endmodule

// File: tb/sim_flash_lock_mgr.sv
module sim_flash_lock_mgr;

    localparam int NB = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = 8'h00;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] start_addr, end_addr;
    logic          busy, done, cmd_err;
    logic [15:0]   wp_status;
    logic [AW-1:0] q_idx = '0;
    logic [2:0]    q_state;

    always #5 clk = ~clk;

    flash_lock_mgr #(.NUM_BLOCKS(NB), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .start_addr(start_addr), .end_addr(end_addr), .busy(busy), .done(done),
        .cmd_err(cmd_err), .wp_status(wp_status), .q_idx(q_idx), .q_state(q_state)
    );

    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    logic [2:0]  m_st [NB];
    logic [15:0] m_wp;
    int          m_first, m_last;
    bit          m_err;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] m_next(logic [7:0] op, logic [2:0] cur);
        if (op == 8'h23 || op == 8'h27) return (cur == 3'b001) ? cur : 3'b100;
        if (op == 8'h2A)                return (cur == 3'b001) ? cur : 3'b010;
        if (op == 8'h2C)                return (cur == 3'b100) ? cur : 3'b001;
        return cur;
    endfunction

    task automatic wr_reg(bit sel, int val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = AW'(val);
        @(negedge clk);
        reg_wr = 1'b0;
        if (!sel) begin
            m_first = val & (NB - 1);
            m_last  = m_first;
        end else begin
            m_last  = val & 255;
        end
        check("R8 start reg", start_addr, m_first);
        check("R8 end reg", end_addr, m_last);
    endtask

    task automatic check_states(string req);
        for (int i = 0; i < NB; i++) begin
            q_idx = AW'(i);
            #1;
            check(req, q_state, m_st[i]);
        end
        q_idx = AW'(NB + 3);
        #1;
        check("R2 out-of-range query", q_state, 3'b000);
    endtask

    // Issue a command, model it, measure walk cycles, then compare everything.
    task automatic run_cmd(logic [7:0] op, bit inject);
        int f, l, n, cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        f = (op == 8'h27) ? 0 : m_first;
        l = (op == 8'h27) ? NB - 1 : m_last;
        n = 0; m_err = 0;
        if (f > l) n = 1;
        else begin
            for (int c = f; ; c++) begin
                n++;
                if (c >= NB) begin m_err = 1; break; end
                if (m_next(op, m_st[c]) != m_st[c]) begin
                    m_st[c] = m_next(op, m_st[c]);
                    m_wp = {13'b0, m_st[c]};
                end
                if (c == l) break;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy after accept", busy, 1'b1);
        cnt = 0;
        while (!done && cnt < 400) begin
            if (inject && cnt == 0) begin
                cmd_valid = 1'b1; cmd_op = 8'h27;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        cmd_valid = 1'b0;
        check("R9 walk cycles", cnt, n);
        check("R9 busy low at done", busy, 1'b0);
        check("R6 error flag", cmd_err, m_err);
        check("R7 wp status", wp_status, m_wp);
        check_states(inject ? "R10 state after busy cmd" : "R3 block state");
        @(negedge clk);
        check("R9 done pulse width", done, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        for (int i = 0; i < NB; i++) m_st[i] = 3'b010;
        m_wp = 16'h0002; m_first = 0; m_last = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wp reset", wp_status, 16'h0002);
        check("R1 busy reset", busy, 1'b0);
        check("R1 done reset", done, 1'b0);
        check("R1 err reset", cmd_err, 1'b0);
        check_states("R1 block reset");

        // R8 masking and copying
        wr_reg(0, 8'hF5);
        wr_reg(1, 8'hE3);
        wr_reg(0, 3);
        wr_reg(1, 6);
        // R3 unlock range 3..6
        run_cmd(8'h23, 0);
        // R5 tight over 2..8: 3..6 unlocked stay, 2,7,8 become tight
        wr_reg(0, 2); wr_reg(1, 8);
        run_cmd(8'h2C, 0);
        // R4 lock over tight and unlocked blocks
        run_cmd(8'h2A, 0);
        // R4 unlock all leaves tight blocks
        run_cmd(8'h27, 0);
        // R7 no-change command keeps wp status
        wr_reg(0, 2); wr_reg(1, 2);
        run_cmd(8'h23, 0);
        // R9 empty range
        wr_reg(0, 9); wr_reg(1, 4);
        run_cmd(8'h2A, 0);
        // R6 range leaves the array, then clears on next command
        wr_reg(0, 12); wr_reg(1, 40);
        run_cmd(8'h2A, 0);
        wr_reg(0, 0); wr_reg(1, 0);
        run_cmd(8'h2A, 0);
        // R10 command during busy ignored
        wr_reg(0, 10); wr_reg(1, 14);
        run_cmd(8'h2A, 1);
        // R10 unknown code ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 8'h55;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10 unknown code busy", busy, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 unknown code done", done, 1'b0);
        check("R10 unknown code wp", wp_status, m_wp);
        check_states("R10 unknown code state");

        // Random mix
        for (int it = 0; it < 150; it++) begin
            int r;
            logic [7:0] op;
            r = $urandom_range(0, 3);
            if (r != 0) wr_reg(0, $urandom_range(0, 255));
            if (r == 2) wr_reg(1, $urandom_range(0, 22));
            r = $urandom_range(0, 9);
            op = (r < 3) ? 8'h23 : (r < 6) ? 8'h2A : (r < 8) ? 8'h2C : 8'h27;
            run_cmd(op, $urandom_range(0, 7) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule